// File: doc/BRIEF.md
# Tiled Pointwise Convolution Engine

This engine computes 1x1 convolutions as a matrix product over fixed-point data that an upstream address generator has already flattened into channel-major vectors. Each input beat carries one slice of `TIN` input channels for one output pixel, together with the matching `TOUT x TIN` weight tile. A multiplier array forms all products of the beat, a per-output-lane adder tree reduces them, and a wide accumulator sums those partial dot products over the successive input-channel slices of the pixel. When the slice marked last has been summed, the bias is added, the sum is scaled down by an arithmetic right shift, saturated to 16 bits and optionally clamped to the ReLU6 range. The result leaves as one `TOUT`-lane output beat with a valid/ready handshake.

The same datapath serves a fully connected layer. In that mode a global-average-pool front end first sums a power-of-two number of pixel beats per channel slice and divides by shifting, and the pooled vector then enters the product path like a single pixel's slice. A stalled output freezes the whole pipeline, so no beat or partial sum is lost.

Top module: `pw_gemm_engine`

## Requirements
- R1: After reset `out_valid` is low and `in_ready` is high.
- R2: Lane `i` of `in_data` is bits `[16i+15:16i]`; weight for output lane `o` and input lane `i` is `w_data[16(o*TIN+i)+15 : 16(o*TIN+i)]`; lane `o` of `bias` and `out_data` is bits `[16o+15:16o]`; all values are signed two's complement. Output lane `o` equals the requantized value of the bias plus the sum over all slices of the pixel of `x_i * w_oi`.
- R3: A beat with `in_first` high discards all earlier accumulation; slices up to and including the one with `in_last` high are summed into one output; a beat with both markers is a complete pixel.
- R4: Requantization adds the sign-extended bias to the accumulated sum and shifts right arithmetically by `shift` (0 to 31), rounding toward minus infinity.
- R5: A shifted result outside [-32768, 32767] saturates to the nearer bound.
- R6: With `relu6_en` high, each output lane is clamped to [0, 1536], where 1536 is six in the 8-fraction-bit format.
- R7: Without a stall, `out_valid` rises on the second rising edge counted from (and including) the edge that accepts the last slice.
- R8: While `out_valid` is high and `out_ready` low, `out_data` holds, `out_valid` stays high and `in_ready` is low; every result is delivered once, in order.
- R9: With `fc_mode` high, each slice is `2^pool_log2` consecutive beats; each lane of the vector fed to the product path is the floor of the lane sum shifted right by `pool_log2`; markers and weights are taken from the beat that closes the group.
- R10: The accumulator is 42 bits wide, so 256 slices of full-scale products sum without wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fc_mode | input | 1 | High: pooled fully connected mode |
| pool_log2 | input | 4 | Log2 of pixels per pooled slice (up to 10) |
| shift | input | 5 | Requantization right-shift amount |
| relu6_en | input | 1 | Enables the ReLU6 clamp |
| bias | input | TOUT*16 | Bias per output lane |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_first | input | 1 | First channel slice of an output pixel |
| in_last | input | 1 | Last channel slice of an output pixel |
| in_data | input | TIN*16 | Input channel slice |
| w_data | input | TIN*TOUT*16 | Weight tile for this slice |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts output |
| out_data | output | TOUT*16 | Requantized output lanes |

## Verification
The bench builds the engine with its defaults: four input and four output lanes, 16-bit data, 8 fraction bits and up to 1024 pooled pixels. With only four lanes per slice, pixels of one to six slices and pooled groups of one, eight and thirty-two beats come cheaply, and a 256-slice pixel of full-scale negative products drives the 42-bit accumulator up to 2^40 within a few hundred cycles. Shifts of 0 and 31 reach both saturation and the accumulator's top bits, while random output stalls exercise the freeze path throughout.

// File: rtl/pwg_pkg.sv
package pwg_pkg;

    // Markers that travel with one channel slice through the pipeline.
    typedef struct packed {
        logic valid;
        logic first;
        logic last;
    } pwg_tag_t;

endpackage

// File: rtl/pwg_pool.sv
module pwg_pool
    import pwg_pkg::*;
#(
    parameter int TIN   = 4,
    parameter int DW    = 16,
    parameter int PMAXL = 10,
    parameter int PLW   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              fc_mode,
    input  logic [PLW-1:0]    pool_log2,
    input  logic              in_valid,
    input  logic              in_first,
    input  logic              in_last,
    input  logic [TIN*DW-1:0] in_data,
    output pwg_tag_t          tile_tag,
    output logic [TIN*DW-1:0] tile_vec
);

    localparam int SW = DW + PMAXL;
    localparam logic signed [SW-1:0] HI = SW'(2 ** (DW - 1) - 1);
    localparam logic signed [SW-1:0] LO = -SW'(2 ** (DW - 1));

    typedef struct packed {
        logic [PMAXL-1:0]          cnt;
        logic [TIN-1:0][SW-1:0]    sum;
    } pool_st_t;

    pool_st_t st_d, st_q;

    logic [PLW-1:0]          eff_d;
    logic [PMAXL-1:0]        mask_d;
    logic                    closing_d;
    logic                    accept_d;
    logic signed [SW-1:0]    tot_d  [TIN];
    logic signed [SW-1:0]    avg_d  [TIN];
    logic [TIN*DW-1:0]       pooled_d;

    always_comb begin
        st_d      = st_q;
        eff_d     = (pool_log2 > PLW'(PMAXL)) ? PLW'(PMAXL) : pool_log2;
        mask_d    = PMAXL'((32'd1 << eff_d) - 32'd1);
        closing_d = (st_q.cnt == mask_d);
        accept_d  = in_valid && en;
        pooled_d  = '0;
        for (int i = 0; i < TIN; i++) begin
            tot_d[i] = $signed(st_q.sum[i]) + SW'($signed(in_data[i*DW +: DW]));
            avg_d[i] = tot_d[i] >>> eff_d;
            if (avg_d[i] > HI) begin
                pooled_d[i*DW +: DW] = HI[DW-1:0];
            end else if (avg_d[i] < LO) begin
                pooled_d[i*DW +: DW] = LO[DW-1:0];
            end else begin
                pooled_d[i*DW +: DW] = avg_d[i][DW-1:0];
            end
        end

        tile_tag.first = in_first;
        tile_tag.last  = in_last;
        if (fc_mode) begin
            tile_tag.valid = accept_d && closing_d;
            tile_vec       = pooled_d;
        end else begin
            tile_tag.valid = accept_d;
            tile_vec       = in_data;
        end

        if (!fc_mode) begin
            st_d = '0;
        end else if (accept_d) begin
            if (closing_d) begin
                st_d = '0;
            end else begin
                st_d.cnt = st_q.cnt + PMAXL'(1);
                for (int i = 0; i < TIN; i++) begin
                    st_d.sum[i] = tot_d[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R9
    pool_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fc_mode |-> (st_q.cnt <= mask_d));

endmodule

// File: rtl/pwg_mac.sv
module pwg_mac
    import pwg_pkg::*;
#(
    parameter int TIN  = 4,
    parameter int TOUT = 4,
    parameter int DW   = 16,
    parameter int ACCW = 42
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  pwg_tag_t             tile_tag,
    input  logic [TIN*DW-1:0]    tile_vec,
    input  logic [TIN*TOUT*DW-1:0] w_data,
    output logic                 fire,
    output logic [TOUT*ACCW-1:0] acc_next
);

    localparam int NP = TIN * TOUT;
    localparam int PW = 2 * DW;
    localparam int SW = PW + $clog2(TIN);

    typedef struct packed {
        pwg_tag_t                     tag;
        logic [NP-1:0][PW-1:0]        prod;
        logic [TOUT-1:0][ACCW-1:0]    acc;
    } mac_st_t;

    mac_st_t st_d, st_q;

    logic signed [SW-1:0]   lsum_d [TOUT];
    logic [ACCW-1:0]        accn_d [TOUT];
    logic signed [DW-1:0]   xs_d, ws_d;

    always_comb begin
        st_d     = st_q;
        acc_next = '0;
        xs_d     = '0;
        ws_d     = '0;
        // adder tree per output lane, then accumulate across slices
        for (int o = 0; o < TOUT; o++) begin
            lsum_d[o] = '0;
            for (int i = 0; i < TIN; i++) begin
                lsum_d[o] = lsum_d[o] + SW'($signed(st_q.prod[o*TIN+i]));
            end
            accn_d[o] = (st_q.tag.first ? '0 : st_q.acc[o]) + ACCW'(lsum_d[o]);
            acc_next[o*ACCW +: ACCW] = accn_d[o];
        end
        fire = st_q.tag.valid && st_q.tag.last;

        if (en) begin
            st_d.tag = tile_tag;
            for (int o = 0; o < TOUT; o++) begin
                for (int i = 0; i < TIN; i++) begin
                    xs_d = $signed(tile_vec[i*DW +: DW]);
                    ws_d = $signed(w_data[(o*TIN+i)*DW +: DW]);
                    st_d.prod[o*TIN+i] = PW'(xs_d) * PW'(ws_d);
                end
                if (st_q.tag.valid) begin
                    st_d.acc[o] = accn_d[o];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8
    mac_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(st_q.acc) && $stable(st_q.tag));

endmodule

// File: rtl/pwg_requant.sv
module pwg_requant #(
    parameter int TOUT = 4,
    parameter int DW   = 16,
    parameter int ACCW = 42,
    parameter int FRAC = 8
) (
    input  logic [TOUT*ACCW-1:0] acc,
    input  logic [TOUT*DW-1:0]   bias,
    input  logic [4:0]           shift,
    input  logic                 relu6_en,
    output logic [TOUT*DW-1:0]   q
);

    localparam int TW = ACCW + 1;
    localparam logic signed [TW-1:0] HI  = TW'(2 ** (DW - 1) - 1);
    localparam logic signed [TW-1:0] LO  = -TW'(2 ** (DW - 1));
    localparam logic signed [DW-1:0] SIX = DW'(6 << FRAC);

    for (genvar o = 0; o < TOUT; o++) begin : g_lane
        logic signed [TW-1:0] t_d, sh_d;
        logic signed [DW-1:0] sat_d, r_d;
        always_comb begin
            t_d  = TW'($signed(acc[o*ACCW +: ACCW])) + TW'($signed(bias[o*DW +: DW]));
            sh_d = t_d >>> shift;
            if (sh_d > HI) begin
                sat_d = HI[DW-1:0];
            end else if (sh_d < LO) begin
                sat_d = LO[DW-1:0];
            end else begin
                sat_d = sh_d[DW-1:0];
            end
            r_d = sat_d;
            if (relu6_en) begin
                if (sat_d < 0) begin
                    r_d = '0;
                end else if (sat_d > SIX) begin
                    r_d = SIX;
                end
            end
        end
        assign q[o*DW +: DW] = r_d;
    end

endmodule

// File: rtl/pw_gemm_engine.sv
module pw_gemm_engine
    import pwg_pkg::*;
#(
    parameter int TIN       = 4,
    parameter int TOUT      = 4,
    parameter int DW        = 16,
    parameter int FRAC      = 8,
    parameter int MAX_TILES = 256,
    parameter int PMAXL     = 10,
    parameter int PLW       = $clog2(PMAXL + 1),
    parameter int ACCW      = 2 * DW + $clog2(TIN) + $clog2(MAX_TILES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fc_mode,
    input  logic [PLW-1:0]         pool_log2,
    input  logic [4:0]             shift,
    input  logic                   relu6_en,
    input  logic [TOUT*DW-1:0]     bias,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic                   in_first,
    input  logic                   in_last,
    input  logic [TIN*DW-1:0]      in_data,
    input  logic [TIN*TOUT*DW-1:0] w_data,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [TOUT*DW-1:0]     out_data
);

    localparam logic signed [DW-1:0] SIX = DW'(6 << FRAC);

    typedef struct packed {
        logic                 out_valid;
        logic [TOUT*DW-1:0]   out_data;
    } top_st_t;

    top_st_t st_d, st_q;

    logic                   en;
    pwg_tag_t               tile_tag;
    logic [TIN*DW-1:0]      tile_vec;
    logic                   fire;
    logic [TOUT*ACCW-1:0]   acc_next;
    logic [TOUT*DW-1:0]     rq;

    assign en       = !st_q.out_valid || out_ready;
    assign in_ready = en;

    pwg_pool #(.TIN(TIN), .DW(DW), .PMAXL(PMAXL), .PLW(PLW)) i_pool (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .fc_mode  (fc_mode),
        .pool_log2(pool_log2),
        .in_valid (in_valid),
        .in_first (in_first),
        .in_last  (in_last),
        .in_data  (in_data),
        .tile_tag (tile_tag),
        .tile_vec (tile_vec)
    );

    pwg_mac #(.TIN(TIN), .TOUT(TOUT), .DW(DW), .ACCW(ACCW)) i_mac (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .tile_tag(tile_tag),
        .tile_vec(tile_vec),
        .w_data  (w_data),
        .fire    (fire),
        .acc_next(acc_next)
    );

    pwg_requant #(.TOUT(TOUT), .DW(DW), .ACCW(ACCW), .FRAC(FRAC)) i_rq (
        .acc     (acc_next),
        .bias    (bias),
        .shift   (shift),
        .relu6_en(relu6_en),
        .q       (rq)
    );

    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.out_valid = fire;
            if (fire) begin
                st_d.out_data = rq;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.out_valid;
    assign out_data  = st_q.out_data;

    logic lanes_ok;
    always_comb begin
        lanes_ok = 1'b1;
        for (int o = 0; o < TOUT; o++) begin
            if ($signed(out_data[o*DW +: DW]) < 0 || $signed(out_data[o*DW +: DW]) > SIX) begin
                lanes_ok = 1'b0;
            end
        end
    end

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R6
    relu_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && relu6_en |-> lanes_ok);

    // R7
    out_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(fire));

endmodule

// File: tb/test_pw_gemm_engine.sv
module test_pw_gemm_engine;

    localparam int TIN = 4, TOUT = 4, DW = 16;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   fc_mode = 1'b0;
    logic [3:0]             pool_log2 = '0;
    logic [4:0]             shift = '0;
    logic                   relu6_en = 1'b0;
    logic [TOUT*DW-1:0]     bias = '0;
    logic                   in_valid = 1'b0;
    logic                   in_ready;
    logic                   in_first = 1'b0;
    logic                   in_last = 1'b0;
    logic [TIN*DW-1:0]      in_data = '0;
    logic [TIN*TOUT*DW-1:0] w_data = '0;
    logic                   out_valid;
    logic                   out_ready = 1'b1;
    logic [TOUT*DW-1:0]     out_data;

    pw_gemm_engine i_pw_gemm_engine (
        .clk(clk), .rst_n(rst_n), .fc_mode(fc_mode), .pool_log2(pool_log2),
        .shift(shift), .relu6_en(relu6_en), .bias(bias),
        .in_valid(in_valid), .in_ready(in_ready), .in_first(in_first),
        .in_last(in_last), .in_data(in_data), .w_data(w_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int ready_mode = 0;            // 0 always ready, 1 random, 2 never
    longint acc_m [TOUT];
    logic [TOUT*DW-1:0] exp_q [$];
    string              req_q [$];

    task automatic check(input string req, input bit ok, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int rnd16();
        return int'($urandom_range(0, 65535)) - 32768;
    endfunction

    function automatic logic [TOUT*DW-1:0] model_out();
        logic [TOUT*DW-1:0] r;
        for (int o = 0; o < TOUT; o++) begin
            longint t;
            t = acc_m[o] + longint'($signed(bias[o*DW +: DW]));
            t = t >>> shift;
            if (t > 32767) t = 32767;
            if (t < -32768) t = -32768;
            if (relu6_en) begin
                if (t < 0) t = 0;
                if (t > 1536) t = 1536;
            end
            r[o*DW +: DW] = 16'(t);
        end
        return r;
    endfunction

    task automatic beat(input logic [TIN*DW-1:0] d, input logic [TIN*TOUT*DW-1:0] w,
                        input bit f, input bit l);
        @(negedge clk);
        in_data = d; w_data = w; in_first = f; in_last = l; in_valid = 1'b1;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // one channel slice: x given per lane (FC mode: P beats, x_b per beat)
    task automatic slice(input int xv [TIN], input int wv [TIN*TOUT], input bit f, input bit l,
                         input string req);
        logic [TIN*DW-1:0] d;
        logic [TIN*TOUT*DW-1:0] w;
        int px [TIN];
        for (int k = 0; k < TIN*TOUT; k++) w[k*DW +: DW] = 16'(wv[k]);
        if (fc_mode) begin
            longint s [TIN];
            int p;
            p = 1 << pool_log2;
            for (int i = 0; i < TIN; i++) s[i] = 0;
            for (int b = 0; b < p; b++) begin
                for (int i = 0; i < TIN; i++) begin
                    int v;
                    v = (b == p - 1) ? xv[i] : rnd16();
                    s[i] += v;
                    d[i*DW +: DW] = 16'(v);
                end
                beat(d, w, f, l);
            end
            for (int i = 0; i < TIN; i++) px[i] = int'(s[i] >>> pool_log2);
        end else begin
            for (int i = 0; i < TIN; i++) begin
                d[i*DW +: DW] = 16'(xv[i]);
                px[i] = xv[i];
            end
            beat(d, w, f, l);
        end
        for (int o = 0; o < TOUT; o++) begin
            if (f) acc_m[o] = 0;
            for (int i = 0; i < TIN; i++) acc_m[o] += longint'(px[i]) * longint'(wv[o*TIN+i]);
        end
        if (l) begin
            exp_q.push_back(model_out());
            req_q.push_back(req);
        end
    endtask

    task automatic rand_pixel(input int ntiles, input string req);
        int xv [TIN];
        int wv [TIN*TOUT];
        for (int t = 0; t < ntiles; t++) begin
            for (int i = 0; i < TIN; i++) xv[i] = rnd16();
            for (int k = 0; k < TIN*TOUT; k++) wv[k] = rnd16() >>> ($urandom_range(0, 8));
            slice(xv, wv, t == 0, t == ntiles - 1, req);
        end
    endtask

    task automatic drain();
        idle();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // output monitor and ready generator
    initial begin
        logic               held_v;
        logic [TOUT*DW-1:0] held_d;
        held_v = 1'b0;
        held_d = '0;
        forever begin
            @(negedge clk);
            case (ready_mode)
                0: out_ready = 1'b1;
                1: out_ready = ($urandom_range(0, 3) != 0);
                default: out_ready = 1'b0;
            endcase
            #2;
            if (held_v) begin
                // R8: stalled output holds
                check("R8", out_valid === 1'b1 && out_data === held_d, out_data, held_d);
            end
            held_v = out_valid && !out_ready && rst_n;
            held_d = out_data;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check("R8", 1'b0, 1, 0);
                end else begin
                    logic [TOUT*DW-1:0] e;
                    string r;
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    for (int o = 0; o < TOUT; o++) begin
                        check(r, out_data[o*DW +: DW] === e[o*DW +: DW],
                              longint'($signed(out_data[o*DW +: DW])), longint'($signed(e[o*DW +: DW])));
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int xv [TIN];
        int wv [TIN*TOUT];
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #2;
        // R1
        check("R1", out_valid === 1'b0, out_valid, 0);
        check("R1", in_ready === 1'b1, in_ready, 1);
        rst_n = 1'b1;

        // R7 latency, single-slice pixel (R3), lane layout (R2)
        shift = 5'd2;
        bias = {16'sd5, -16'sd7, 16'sd0, 16'sd100};
        for (int i = 0; i < TIN; i++) xv[i] = i + 1;
        for (int k = 0; k < TIN*TOUT; k++) wv[k] = k - 5;
        slice(xv, wv, 1'b1, 1'b1, "R2");
        @(negedge clk);
        in_valid = 1'b0;
        #2;
        check("R7", out_valid === 1'b0, out_valid, 0);
        @(negedge clk);
        #1;
        check("R7", out_valid === 1'b1, out_valid, 1);
        drain();

        // R5 saturation high and low
        shift = 5'd0;
        bias = '0;
        for (int i = 0; i < TIN; i++) xv[i] = 32767;
        for (int k = 0; k < TIN*TOUT; k++) wv[k] = (k < 8) ? 32767 : -32768;
        slice(xv, wv, 1'b1, 1'b1, "R5");
        drain();

        // R4 floor rounding of negative results
        shift = 5'd1;
        bias = {16'sd0, -16'sd1, 16'sd1, 16'sd0};
        for (int i = 0; i < TIN; i++) xv[i] = (i == 0) ? -3 : 0;
        for (int k = 0; k < TIN*TOUT; k++) wv[k] = 1;
        slice(xv, wv, 1'b1, 1'b1, "R4");
        drain();

        // R6 ReLU6 clamp
        relu6_en = 1'b1;
        shift = 5'd8;
        for (int n = 0; n < 6; n++) rand_pixel(2, "R6");
        drain();
        relu6_en = 1'b0;

        // R8 stall: output held, input blocked, then released
        ready_mode = 2;
        shift = 5'd10;
        rand_pixel(1, "R8");
        idle();
        repeat (4) @(negedge clk);
        #2;
        check("R8", out_valid === 1'b1, out_valid, 1);
        check("R8", in_ready === 1'b0, in_ready, 0);
        ready_mode = 0;
        drain();

        // R10 256 full-scale slices
        shift = 5'd31;
        bias = '0;
        for (int i = 0; i < TIN; i++) xv[i] = -32768;
        for (int k = 0; k < TIN*TOUT; k++) wv[k] = -32768;
        for (int t = 0; t < 256; t++) slice(xv, wv, t == 0, t == 255, "R10");
        drain();

        // R3 multi-slice pixels under random backpressure
        ready_mode = 1;
        for (int n = 0; n < 40; n++) begin
            if (n % 8 == 0) begin
                drain();
                shift = 5'($urandom_range(8, 24));
                relu6_en = ($urandom_range(0, 1) == 1);
                for (int o = 0; o < TOUT; o++) bias[o*DW +: DW] = 16'(rnd16());
            end
            rand_pixel(int'($urandom_range(1, 6)), "R3");
        end
        drain();

        // R9 pooled fully connected mode
        fc_mode = 1'b1;
        relu6_en = 1'b0;
        shift = 5'd14;
        for (int pl = 0; pl < 3; pl++) begin
            pool_log2 = (pl == 0) ? 4'd0 : (pl == 1) ? 4'd3 : 4'd5;
            for (int n = 0; n < 3; n++) rand_pixel(int'($urandom_range(1, 4)), "R9");
            drain();
        end
        fc_mode = 1'b0;
        ready_mode = 0;

        check("R8", exp_q.size() == 0, exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule